// File: doc/BRIEF.md
# Rational-Ratio Phase Control for a Time-Variant Resampler

This block steers a time-variant filter that changes a stream's sample rate by a rational factor L/M, with L smaller than M. It runs on the input sample clock and treats every clock as one input sample. A modulo-M accumulator grows by L on each cycle. Whenever the sum reaches or passes M, it wraps and the block raises a strobe that asks the filter for a new output sample. The strobes come at irregular intervals, but on average there are L of them for every M input cycles.

With each strobe the block presents a phase index. The index is derived from the remainder j that the wrap leaves behind: mu = L-1-j. The block also presents a chain of running products built from that phase, which the filter uses as its weights: mu+1, (mu+1)(mu+2), and so on, up to NTERM terms (at most four). The strobe, the phase and all products are registered and change together. Between strobes they keep their values, so the filter can pick them up at any time until the next strobe.

The ratio inputs are taken in only on a load pulse. The same pulse clears the accumulator, so a new ratio always starts from phase zero.

Top module: `rsrc_phase_ctl`

## Requirements
- R1: While `rst` is high (synchronous, active high), the accumulator is cleared and `strobe`, `mu` and every product field read 0. The ratio takes its default values: L=DEF_L, M=DEF_M.
- R2: Count clock edges from the last load edge. At edge k, `strobe` is 1 exactly when floor(k·L/M) is greater than floor((k-1)·L/M). After n edges, the number of strobes is therefore floor(n·L/M).
- R3: After a strobe edge k, `mu` equals L-1-((k·L) mod M). This value is always below L.
- R4: On a strobe, the field at bits [PW-1:0] of `mu_prod` holds the first product, mu+1.
- R5: On a strobe, product i (for i from 2 to NTERM) equals product i-1 multiplied by (mu+i).
- R6: After any edge without a strobe, `mu` and `mu_prod` keep the values they had before that edge.
- R7: `ratio_l` and `ratio_m` have no effect unless `load` is high at a clock edge. That edge stores them, clears the accumulator and drives `strobe` to 0.
- R8: Product i is placed at bits [i·PW-1 : (i-1)·PW] of `mu_prod`, where PW = NTERM·(AW+1). The first product sits in the lowest field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sample clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Stores the ratio inputs and clears the accumulator |
| ratio_l | input | AW | Step L that the accumulator adds each cycle (must be less than ratio_m) |
| ratio_m | input | AW | Modulus M of the accumulator |
| strobe | output | 1 | A new output sample is due |
| mu | output | AW | Phase index L-1-j, held between strobes |
| mu_prod | output | NTERM·PW | Running products, product 1 in the lowest field |

## Verification
A wrap and the output update that it causes can land in the same cycle as a load pulse. Two wraps can also follow on back-to-back cycles. The bench brings about both. It reloads the ratio in the middle of a run, while the accumulator is not zero, and it uses ratios close to 1 (for example 7/8 and 254/255), where strobes come on consecutive cycles. It judges each case by comparing every cycle against values from the closed-form formulas: the strobe from floor(k·L/M), and the phase from (k·L) mod M. In the load cycle itself, the strobe must be 0.

// File: rtl/rsrc_pkg.sv
package rsrc_pkg;

    localparam int MAX_TERMS = 4;

    // Width of one product field: n factors, each up to acc_w+1 bits wide
    function automatic int prod_width(input int acc_w, input int n_terms);
        return n_terms * (acc_w + 1);
    endfunction

endpackage

// File: rtl/rsrc_ratio_reg.sv
module rsrc_ratio_reg #(
    parameter int AW    = 8,
    parameter int DEF_L = 1,
    parameter int DEF_M = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] l_in,
    input  logic [AW-1:0] m_in,
    output logic [AW-1:0] l_q,
    output logic [AW-1:0] m_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            l_q <= AW'(DEF_L);
            m_q <= AW'(DEF_M);
        end else if (load) begin
            l_q <= l_in;
            m_q <= m_in;
        end
    end

endmodule

// File: rtl/rsrc_wrap_acc.sv
module rsrc_wrap_acc #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] modulus,
    output logic          wrap,
    output logic [AW-1:0] rem
);

    typedef struct packed {
        logic          wrap;
        logic [AW-1:0] rem;
    } acc_step_t;

    logic [AW-1:0] acc_q;
    logic [AW:0]   sum;
    acc_step_t     nxt;

    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, step};
        if (sum >= {1'b0, modulus}) begin
            nxt.wrap = 1'b1;
            nxt.rem  = AW'(sum - {1'b0, modulus});
        end else begin
            nxt.wrap = 1'b0;
            nxt.rem  = AW'(sum);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) acc_q <= '0;
        else             acc_q <= nxt.rem;
    end

    assign wrap = nxt.wrap;
    assign rem  = nxt.rem;

endmodule

// File: rtl/rsrc_coef_chain.sv
module rsrc_coef_chain #(
    parameter int AW    = 8,
    parameter int NTERM = 4,
    parameter int PW    = rsrc_pkg::prod_width(AW, NTERM)
) (
    input  logic [AW-1:0]       mu,
    output logic [NTERM*PW-1:0] prod
);

    logic [PW-1:0] fac  [NTERM];
    logic [PW-1:0] part [NTERM];

    for (genvar i = 0; i < NTERM; i++) begin : g_term
        assign fac[i] = PW'(mu) + PW'(i + 1);
        if (i == 0) begin : g_first
            assign part[i] = fac[i];
        end else begin : g_next
            assign part[i] = part[i-1] * fac[i];
        end
        assign prod[i*PW +: PW] = part[i];
    end

endmodule

// File: rtl/rsrc_phase_ctl.sv
module rsrc_phase_ctl #(
    parameter int AW    = 8,
    parameter int NTERM = 4,
    parameter int DEF_L = 1,
    parameter int DEF_M = 2,
    localparam int PW   = rsrc_pkg::prod_width(AW, NTERM)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [AW-1:0]       ratio_l,
    input  logic [AW-1:0]       ratio_m,
    output logic                strobe,
    output logic [AW-1:0]       mu,
    output logic [NTERM*PW-1:0] mu_prod
);

    initial begin
        if (NTERM < 1 || NTERM > rsrc_pkg::MAX_TERMS)
            $error("NTERM out of range");
    end

    logic [AW-1:0]       l_q, m_q, rem;
    logic                wrap;
    logic [AW-1:0]       mu_nxt;
    logic [NTERM*PW-1:0] prod_nxt;

    rsrc_ratio_reg #(.AW(AW), .DEF_L(DEF_L), .DEF_M(DEF_M)) u_cfg (
        .clk(clk), .rst(rst), .load(load),
        .l_in(ratio_l), .m_in(ratio_m), .l_q(l_q), .m_q(m_q)
    );

    rsrc_wrap_acc #(.AW(AW)) u_acc (
        .clk(clk), .rst(rst), .load(load),
        .step(l_q), .modulus(m_q), .wrap(wrap), .rem(rem)
    );

    // phase index from the remainder left by the wrap
    assign mu_nxt = l_q - AW'(1) - rem;

    rsrc_coef_chain #(.AW(AW), .NTERM(NTERM), .PW(PW)) u_chain (
        .mu(mu_nxt), .prod(prod_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe  <= 1'b0;
            mu      <= '0;
            mu_prod <= '0;
        end else if (load) begin
            strobe  <= 1'b0;
        end else begin
            strobe <= wrap;
            if (wrap) begin
                mu      <= mu_nxt;
                mu_prod <= prod_nxt;
            end
        end
    end

endmodule

// File: rtl/rsrc_phase_chk.sv
module rsrc_phase_chk #(
    parameter int AW    = 8,
    parameter int NTERM = 4,
    parameter int DEF_L = 1,
    parameter int DEF_M = 2,
    parameter int PW    = rsrc_pkg::prod_width(AW, NTERM)
) (
    input logic                clk,
    input logic                rst,
    input logic                load,
    input logic [AW-1:0]       ratio_l,
    input logic [AW-1:0]       ratio_m,
    input logic                strobe,
    input logic [AW-1:0]       mu,
    input logic [NTERM*PW-1:0] mu_prod
);

    logic [AW-1:0] cfg_l, cfg_m;
    logic [31:0]   n_cyc, n_stb;
    logic [63:0]   s_tot, lhs, rhs;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_l <= AW'(DEF_L);
            cfg_m <= AW'(DEF_M);
            n_cyc <= '0;
            n_stb <= '0;
        end else if (load) begin
            cfg_l <= ratio_l;
            cfg_m <= ratio_m;
            n_cyc <= '0;
            n_stb <= '0;
        end else begin
            n_cyc <= n_cyc + 32'd1;
            n_stb <= n_stb + {31'd0, strobe};
        end
    end

    always_comb begin
        s_tot = 64'(n_stb) + 64'(strobe);
        lhs   = s_tot * 64'(cfg_m);
        rhs   = 64'(n_cyc) * 64'(cfg_l);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (!strobe && mu == '0 && mu_prod == '0)); // R1
    AST_STROBE_RATE: assert property (@(posedge clk) disable iff (rst) (lhs <= rhs) && (rhs < lhs + 64'(cfg_m))); // R2
    AST_MU_BELOW_L: assert property (@(posedge clk) disable iff (rst) strobe |-> (mu < cfg_l)); // R3
    AST_FIRST_TERM: assert property (@(posedge clk) disable iff (rst) strobe |-> (mu_prod[PW-1:0] == PW'(mu) + PW'(1))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !strobe |-> ($stable(mu) && $stable(mu_prod))); // R6
    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst) load |=> !strobe); // R7

    for (genvar i = 1; i < NTERM; i++) begin : g_chain
        AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (rst) strobe |-> (mu_prod[i*PW +: PW] == PW'(mu_prod[(i-1)*PW +: PW] * (PW'(mu) + PW'(i + 1))))); // R5
    end

endmodule

bind rsrc_phase_ctl rsrc_phase_chk #(
    .AW(AW), .NTERM(NTERM), .DEF_L(DEF_L), .DEF_M(DEF_M), .PW(PW)
) u_chk (
    .clk(clk), .rst(rst), .load(load), .ratio_l(ratio_l), .ratio_m(ratio_m),
    .strobe(strobe), .mu(mu), .mu_prod(mu_prod)
);

// File: tb/sim_rsrc_phase_ctl.sv
module sim_rsrc_phase_ctl;

    localparam int  CLK_PERIOD = 10;
    localparam int  AW    = 8;
    localparam int  NTERM = 4;
    localparam int  PW    = NTERM * (AW + 1);
    localparam longint WATCH = 200000;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                load = 1'b0;
    logic [AW-1:0]       ratio_l = '0;
    logic [AW-1:0]       ratio_m = '0;
    logic                strobe;
    logic [AW-1:0]       mu;
    logic [NTERM*PW-1:0] mu_prod;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsrc_phase_ctl #(.AW(AW), .NTERM(NTERM), .DEF_L(1), .DEF_M(2)) u0 (
        .clk(clk), .rst(rst), .load(load), .ratio_l(ratio_l), .ratio_m(ratio_m),
        .strobe(strobe), .mu(mu), .mu_prod(mu_prod)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(strobe == 1'b0, "R1 strobe", longint'(strobe), 0);
        chk(mu == '0, "R1 mu", longint'(mu), 0);
        chk(mu_prod == '0, "R1 products", longint'(mu_prod[PW-1:0]), 0);
        rst = 1'b0;
    endtask

    // loads L/M, then drives unrelated ratio values (must be ignored) and
    // compares every cycle against the closed-form expectations
    task automatic t_ratio(input int L, input int M, input int n, input int gl, input int gm);
        longint exp_mu, p, strobes;
        logic [AW-1:0]       prev_mu;
        logic [NTERM*PW-1:0] prev_prod;
        bit exp_s;
        @(negedge clk);
        load = 1'b1; ratio_l = AW'(L); ratio_m = AW'(M);
        @(negedge clk);
        load = 1'b0; ratio_l = AW'(gl); ratio_m = AW'(gm);
        chk(strobe == 1'b0, "R7 no strobe after load", longint'(strobe), 0);
        prev_mu = mu; prev_prod = mu_prod;
        strobes = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            exp_s = ((longint'(k) * L) / M) != ((longint'(k - 1) * L) / M);
            chk(strobe == exp_s, "R2/R7 strobe", longint'(strobe), longint'(exp_s));
            if (exp_s) begin
                strobes++;
                exp_mu = L - 1 - ((longint'(k) * L) % M);
                chk(longint'(mu) == exp_mu, "R3 mu", longint'(mu), exp_mu);
                p = 1;
                for (int i = 1; i <= NTERM; i++) begin
                    p = p * (exp_mu + i);
                    chk(longint'(mu_prod[(i-1)*PW +: PW]) == p,
                        (i == 1) ? "R4 first product" : "R5 R8 product field",
                        longint'(mu_prod[(i-1)*PW +: PW]), p);
                end
            end else begin
                chk(mu == prev_mu && mu_prod == prev_prod, "R6 hold",
                    longint'(mu), longint'(prev_mu));
            end
            prev_mu = mu; prev_prod = mu_prod;
        end
        chk(strobes == (longint'(n) * L) / M, "R2 strobe count", strobes, (longint'(n) * L) / M);
    endtask

    initial begin
        #(CLK_PERIOD * WATCH);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ratio(3, 5, 40, 9, 10);       // basic ratio
        t_ratio(1, 7, 30, 200, 201);    // sparse strobes, long holds (R6)
        t_ratio(7, 8, 30, 1, 3);        // back-to-back strobes
        repeat (3) @(negedge clk);      // accumulator now nonzero
        t_ratio(46, 57, 200, 2, 250);   // reload mid-run clears phase (R7)
        t_ratio(254, 255, 600, 5, 6);   // largest phase values
        t_ratio(1, 2, 20, 100, 101);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule